// File: doc/BRIEF.md
# Stream Table Entry Address Walker

This block sits at the front of an IO address translation unit. Given the stream identifier of an incoming device transaction, it works out where in memory that stream's table entry lives. It does not fetch or decode the entry. It only produces the address, or a fault code with the address that caused the fault.

Software describes the table through a few configuration inputs. These are a 64-bit base register, a layout select, a table size exponent and a split point, plus an implementation limit on stream ID width. In the flat layout, the entry address is computed directly. In the two-level layout, the block reads one 8-byte first-level descriptor through a simple read port. It then combines the second-level pointer in that descriptor with the low part of the stream ID. Only one lookup is in flight at a time. The configuration is captured when a request is accepted, so a walk in progress does not see later changes.

Top module: `ste_addr_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and both `res_valid` and `rd_req` are 0.
- R2: A stream ID greater than or equal to 2^min(`cfg_log2size`, `cfg_impl_sidw`) completes with `res_code` = 1 (bad stream ID) and `res_addr` = 0. The bound value itself faults. No memory read is issued.
- R3: Before any use, the base register is reduced to its bits [51:6]. All bits above 51 and below 6 are treated as zero.
- R4: In the flat layout (`cfg_two_level` = 0), the masked base also has its low (`cfg_log2size` + 5) bits cleared. The result is `res_code` = 0 and `res_addr` = base + ID × 64, with no memory read.
- R5: In the two-level layout, the masked base has its low max(5, `cfg_log2size` − `cfg_split` + 2) bits cleared, regardless of `cfg_impl_sidw`. Exactly one read is issued at `rd_addr` = base + (ID >> `cfg_split`) × 8.
- R6: The descriptor holds the second-level pointer in bits [51:6] and a span in bits [4:0]. On success, `res_code` = 0 and `res_addr` = ({desc[51:6], 6'b0}) + (ID & (2^`cfg_split` − 1)) × 64.
- R7: A span of 0, or a second-level index of 2^(span−1) or more, completes with `res_code` = 2 (bad entry) and `res_addr` = the descriptor address.
- R8: A read answered with `rd_rerr` = 1 completes with `res_code` = 3 (fetch fault) and `res_addr` = the descriptor address. In that case, `res_evt_w7` holds address bits [63:32] and `res_evt_w6` holds bits [31:0]. For every other code, both words are 0.
- R9: `req_ready` is low from acceptance until the result. `rd_req` and `rd_addr` hold steady until `rd_gnt`. Each accepted request yields exactly one single-cycle `res_valid` pulse.
- R10: Configuration inputs are sampled in the accept cycle. Changes made afterwards do not affect that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_sid | input | SID_W | Stream identifier |
| cfg_base | input | 64 | Table base register |
| cfg_two_level | input | 1 | 0 flat, 1 two-level layout |
| cfg_log2size | input | 6 | Table size exponent |
| cfg_split | input | 5 | Two-level split point |
| cfg_impl_sidw | input | 6 | Implementation stream ID width |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | 64 | Descriptor read address |
| rd_gnt | input | 1 | Read request taken |
| rd_rvalid | input | 1 | Read response valid |
| rd_rdata | input | 64 | Read response data |
| rd_rerr | input | 1 | Read response error |
| res_valid | output | 1 | Result pulse |
| res_code | output | 2 | 0 ok, 1 bad ID, 2 bad entry, 3 fetch fault |
| res_addr | output | 64 | Entry address or fault address |
| res_evt_w6 | output | 32 | Event word 6: fault address low half |
| res_evt_w7 | output | 32 | Event word 7: fault address high half |

## Verification
Result delivery and request acceptance can land in the same cycle. When a walk finishes, `res_valid` rises as the block returns to idle, and the next waiting request is accepted while that pulse is still high. The bench provokes this by queuing lookups back to back. It also scrambles every configuration input right after each acceptance. The scoreboard then requires each result to match the configuration seen in its own accept cycle, arriving in order with the read count expected for its layout.

// File: rtl/ste_walk_pkg.sv
package ste_walk_pkg;

  localparam int unsigned ADDR_W    = 64;
  localparam int unsigned ENT_SHIFT = 6;   // 64-byte stream table entries
  localparam int unsigned L1_SHIFT  = 3;   // 8-byte first-level descriptors
  localparam logic [ADDR_W-1:0] BASE_KEEP = 64'h000F_FFFF_FFFF_FFC0;

  typedef enum logic [1:0] {
    FLT_NONE      = 2'd0,
    FLT_BAD_SID   = 2'd1,
    FLT_BAD_ENTRY = 2'd2,
    FLT_FETCH     = 2'd3
  } flt_e;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_EVAL  = 2'd1,
    WS_ISSUE = 2'd2,
    WS_WAIT  = 2'd3
  } walk_st_e;

  function automatic logic [ADDR_W-1:0] clear_low(input logic [ADDR_W-1:0] a,
                                                  input logic [6:0] sh);
    logic [ADDR_W-1:0] keep;
    if (sh >= 7'd64) keep = '0;
    else             keep = ~((64'd1 << sh) - 64'd1);
    return a & keep;
  endfunction

endpackage

// File: rtl/ste_sid_check.sv
module ste_sid_check #(
  parameter int unsigned SID_W = 20
) (
  input  logic [SID_W-1:0] sid,
  input  logic [5:0]       log2size,
  input  logic [5:0]       impl_w,
  output logic             out_of_range
);
  logic [5:0] lim;

  always_comb begin
    lim = (log2size < impl_w) ? log2size : impl_w;
    if (int'(lim) < int'(SID_W)) out_of_range = ((sid >> lim) != '0);
    else                         out_of_range = 1'b0;
  end
endmodule

// File: rtl/ste_sid_split.sv
module ste_sid_split #(
  parameter int unsigned SID_W = 20
) (
  input  logic [SID_W-1:0] sid,
  input  logic [4:0]       split,
  output logic [SID_W-1:0] l1_idx,
  output logic [SID_W-1:0] l2_idx
);
  logic [SID_W-1:0] low_mask;

  always_comb begin
    low_mask = ~({SID_W{1'b1}} << split);
    l1_idx   = sid >> split;
    l2_idx   = sid & low_mask;
  end
endmodule

// File: rtl/ste_base_align.sv
module ste_base_align
  import ste_walk_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic              two_level,
  input  logic [5:0]        log2size,
  input  logic [4:0]        split,
  output logic [ADDR_W-1:0] aligned
);
  logic [ADDR_W-1:0] masked;
  logic [6:0]        lin_sh;
  logic signed [7:0] two_raw;
  logic [6:0]        two_sh;
  logic [6:0]        sh;

  always_comb begin
    masked  = base & BASE_KEEP;
    lin_sh  = {1'b0, log2size} + 7'd5;
    two_raw = $signed({2'b00, log2size}) - $signed({3'b000, split}) + 8'sd2;
    two_sh  = (two_raw < 8'sd5) ? 7'd5 : two_raw[6:0];
    sh      = two_level ? two_sh : lin_sh;
    aligned = clear_low(masked, sh);
  end
endmodule

// File: rtl/ste_l1_decode.sv
module ste_l1_decode
  import ste_walk_pkg::*;
#(
  parameter int unsigned SID_W = 20
) (
  input  logic [ADDR_W-1:0] desc,
  input  logic [SID_W-1:0]  l2_idx,
  output logic              bad,
  output logic [ADDR_W-1:0] entry_addr
);
  localparam int unsigned PAD = ADDR_W - SID_W;

  logic [4:0]        span;
  logic [4:0]        span_m1;
  logic [ADDR_W-1:0] l2_ptr;

  always_comb begin
    span       = desc[4:0];
    span_m1    = span - 5'd1;
    l2_ptr     = {12'b0, desc[51:6], 6'b0};
    bad        = (span == 5'd0) || ((l2_idx >> span_m1) != '0);
    entry_addr = l2_ptr + ({{PAD{1'b0}}, l2_idx} << ENT_SHIFT);
  end
endmodule

// File: rtl/ste_addr_walker.sv
module ste_addr_walker
  import ste_walk_pkg::*;
#(
  parameter int unsigned SID_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SID_W-1:0]  req_sid,
  input  logic [63:0]       cfg_base,
  input  logic              cfg_two_level,
  input  logic [5:0]        cfg_log2size,
  input  logic [4:0]        cfg_split,
  input  logic [5:0]        cfg_impl_sidw,
  output logic              rd_req,
  output logic [63:0]       rd_addr,
  input  logic              rd_gnt,
  input  logic              rd_rvalid,
  input  logic [63:0]       rd_rdata,
  input  logic              rd_rerr,
  output logic              res_valid,
  output logic [1:0]        res_code,
  output logic [63:0]       res_addr,
  output logic [31:0]       res_evt_w6,
  output logic [31:0]       res_evt_w7
);
  localparam int unsigned PAD = ADDR_W - SID_W;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  walk_st_e          state_q, state_d;
  logic [SID_W-1:0]  sid_q;
  logic [ADDR_W-1:0] base_q;
  logic              two_q;
  logic [5:0]        l2s_q;
  logic [4:0]        split_q;
  logic [5:0]        impl_q;
  logic [ADDR_W-1:0] l1addr_q;
  logic              res_valid_q, res_valid_d;
  flt_e              res_code_q, res_code_d;
  logic [ADDR_W-1:0] res_addr_q, res_addr_d;
  logic [ADDR_W-1:0] evt_q, evt_d;

  logic              cap_en, l1_en;
  logic              sid_oor, desc_bad;
  logic [SID_W-1:0]  l1_idx, l2_idx;
  logic [ADDR_W-1:0] abase, lin_entry, l1_desc, l2_entry;

  ste_sid_check #(.SID_W(SID_W)) u_sid (
    .sid(sid_q), .log2size(l2s_q), .impl_w(impl_q), .out_of_range(sid_oor)
  );

  ste_sid_split #(.SID_W(SID_W)) u_split (
    .sid(sid_q), .split(split_q), .l1_idx(l1_idx), .l2_idx(l2_idx)
  );

  ste_base_align u_base (
    .base(base_q), .two_level(two_q), .log2size(l2s_q), .split(split_q),
    .aligned(abase)
  );

  ste_l1_decode #(.SID_W(SID_W)) u_dec (
    .desc(rd_rdata), .l2_idx(l2_idx), .bad(desc_bad), .entry_addr(l2_entry)
  );

  assign lin_entry = abase + ({{PAD{1'b0}}, sid_q}  << ENT_SHIFT);
  assign l1_desc   = abase + ({{PAD{1'b0}}, l1_idx} << L1_SHIFT);
  assign cap_en    = req_valid && req_ready;

  // next-state and result
  always_comb begin
    state_d     = state_q;
    res_valid_d = 1'b0;
    res_code_d  = res_code_q;
    res_addr_d  = res_addr_q;
    l1_en       = 1'b0;
    unique case (state_q)
      WS_IDLE: if (cap_en) state_d = WS_EVAL;
      WS_EVAL: begin
        if (sid_oor) begin
          res_valid_d = 1'b1;
          res_code_d  = FLT_BAD_SID;
          res_addr_d  = '0;
          state_d     = WS_IDLE;
        end else if (!two_q) begin
          res_valid_d = 1'b1;
          res_code_d  = FLT_NONE;
          res_addr_d  = lin_entry;
          state_d     = WS_IDLE;
        end else begin
          l1_en   = 1'b1;
          state_d = WS_ISSUE;
        end
      end
      WS_ISSUE: if (rd_gnt) state_d = WS_WAIT;
      WS_WAIT: begin
        if (rd_rvalid) begin
          res_valid_d = 1'b1;
          state_d     = WS_IDLE;
          if (rd_rerr) begin
            res_code_d = FLT_FETCH;
            res_addr_d = l1addr_q;
          end else if (desc_bad) begin
            res_code_d = FLT_BAD_ENTRY;
            res_addr_d = l1addr_q;
          end else begin
            res_code_d = FLT_NONE;
            res_addr_d = l2_entry;
          end
        end
      end
      default: state_d = WS_IDLE;
    endcase
    evt_d = (res_code_d == FLT_FETCH) ? res_addr_d : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q     <= WS_IDLE;
      res_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      res_valid_q <= res_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      sid_q   <= '0;
      base_q  <= '0;
      two_q   <= 1'b0;
      l2s_q   <= '0;
      split_q <= '0;
      impl_q  <= '0;
    end else if (cap_en) begin
      sid_q   <= req_sid;
      base_q  <= cfg_base;
      two_q   <= cfg_two_level;
      l2s_q   <= cfg_log2size;
      split_q <= cfg_split;
      impl_q  <= cfg_impl_sidw;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)   l1addr_q <= '0;
    else if (l1_en) l1addr_q <= l1_desc;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      res_code_q <= FLT_NONE;
      res_addr_q <= '0;
      evt_q      <= '0;
    end else if (res_valid_d) begin
      res_code_q <= res_code_d;
      res_addr_q <= res_addr_d;
      evt_q      <= evt_d;
    end
  end

  assign req_ready  = (state_q == WS_IDLE);
  assign rd_req     = (state_q == WS_ISSUE);
  assign rd_addr    = l1addr_q;
  assign res_valid  = res_valid_q;
  assign res_code   = res_code_q;
  assign res_addr   = res_addr_q;
  assign res_evt_w6 = evt_q[31:0];
  assign res_evt_w7 = evt_q[63:32];

endmodule

// File: rtl/ste_walker_chk.sv
module ste_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rd_req,
  input logic        rd_gnt,
  input logic [63:0] rd_addr,
  input logic        res_valid,
  input logic [1:0]  res_code,
  input logic [63:0] res_addr,
  input logic [31:0] res_evt_w6,
  input logic [31:0] res_evt_w7
);
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);                                          // R9
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);                           // R9
  AST_NOT_READY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !req_ready);                                             // R9
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr)));              // R9
  AST_DESC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[2:0] == 3'b000));                               // R5
  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'd0) |-> (res_addr[5:0] == 6'd0));       // R4
  AST_FETCH_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'd3) |-> ({res_evt_w7, res_evt_w6} == res_addr)); // R8
  AST_WORDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code != 2'd3) |-> (res_evt_w7 == 32'd0 && res_evt_w6 == 32'd0)); // R8
  AST_BAD_SID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'd1) |-> (res_addr == 64'd0));           // R2
endmodule

bind ste_addr_walker ste_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_addr(rd_addr), .res_valid(res_valid),
  .res_code(res_code), .res_addr(res_addr), .res_evt_w6(res_evt_w6),
  .res_evt_w7(res_evt_w7)
);

// File: tb/sim_ste_addr_walker.sv
`timescale 1ns/1ps
module sim_ste_addr_walker;
  localparam int SID_W = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready;
  logic [SID_W-1:0] req_sid;
  logic [63:0] cfg_base;
  logic cfg_two_level;
  logic [5:0] cfg_log2size, cfg_impl_sidw;
  logic [4:0] cfg_split;
  logic rd_req, rd_gnt, rd_rvalid, rd_rerr;
  logic [63:0] rd_addr, rd_rdata;
  logic res_valid;
  logic [1:0] res_code;
  logic [63:0] res_addr;
  logic [31:0] res_evt_w6, res_evt_w7;

  always #2 clk = ~clk;

  ste_addr_walker #(.SID_W(SID_W)) u0 (.*);

  typedef struct {
    logic [1:0]  code;
    logic [63:0] addr;
    int          reads;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0, n_rd = 0, rd_at_last = 0;
  logic [63:0] mem_desc;
  logic mem_err;
  int gnt_dly;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] clr(input logic [63:0] a, input int sh);
    if (sh >= 64) return 64'd0;
    return a & ~((64'd1 << sh) - 64'd1);
  endfunction

  // reference from the requirements
  function automatic exp_t model(input logic [SID_W-1:0] sid, input logic [63:0] base,
      input bit two, input int l2s, input int split, input int impl,
      input logic [63:0] desc, input bit err, input string tag);
    exp_t e;
    int lim, sh, span;
    logic [63:0] mb, ab, l1, l2i;
    e.tag = tag; e.reads = 0; e.code = 2'd0;
    lim = (l2s < impl) ? l2s : impl;
    if (lim < SID_W && (64'(sid) >= (64'd1 << lim))) begin
      e.code = 2'd1; e.addr = 0; return e;
    end
    mb = base & 64'h000F_FFFF_FFFF_FFC0;
    if (!two) begin
      e.addr = clr(mb, l2s + 5) + 64'(sid) * 64;
      return e;
    end
    sh = l2s - split + 2;
    if (sh < 5) sh = 5;
    ab = clr(mb, sh);
    l1 = ab + (64'(sid) >> split) * 8;
    e.reads = 1;
    l2i = 64'(sid) & ((64'd1 << split) - 1);
    span = int'(desc[4:0]);
    if (err) begin e.code = 2'd3; e.addr = l1; end
    else if (span == 0 || l2i >= (64'd1 << (span - 1))) begin e.code = 2'd2; e.addr = l1; end
    else e.addr = {12'b0, desc[51:6], 6'b0} + l2i * 64;
    return e;
  endfunction

  task automatic send(input logic [SID_W-1:0] sid, input logic [63:0] base,
      input bit two, input int l2s, input int split, input int impl,
      input logic [63:0] desc, input bit err, input int gd, input bit scramble,
      input string tag);
    while (!req_ready) @(negedge clk);
    mem_desc = desc; mem_err = err; gnt_dly = gd;
    req_sid = sid; cfg_base = base; cfg_two_level = two;
    cfg_log2size = 6'(l2s); cfg_split = 5'(split); cfg_impl_sidw = 6'(impl);
    req_valid = 1'b1;
    q.push_back(model(sid, base, two, l2s, split, impl, desc, err, tag));
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin   // R10: changes after acceptance must not matter
      cfg_base = ~base; cfg_two_level = ~two; cfg_log2size = 6'd1;
      cfg_split = 5'd0; cfg_impl_sidw = 6'd1; req_sid = ~sid;
    end
  endtask

  // memory model
  initial begin
    rd_gnt = 0; rd_rvalid = 0; rd_rerr = 0; rd_rdata = 0;
    forever begin
      @(negedge clk);
      if (rd_req) begin
        check(req_ready == 1'b0, "R9 ready low during read", 64'(req_ready), 0);
        repeat (gnt_dly) begin
          @(negedge clk);
          check(rd_req == 1'b1, "R9 read request held", 64'(rd_req), 1);
        end
        rd_gnt = 1; n_rd++;
        @(negedge clk);
        rd_gnt = 0;
        repeat (2) @(negedge clk);
        rd_rvalid = 1; rd_rdata = mem_desc; rd_rerr = mem_err;
        @(negedge clk);
        rd_rvalid = 0; rd_rerr = 0; rd_rdata = 64'hDEAD_BEEF_DEAD_BEEF;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && res_valid) begin
        if (q.size() == 0) begin
          check(0, "R9 unexpected result", 64'(res_code), 0);
        end else begin
          exp_t e;
          logic [63:0] ew;
          e = q.pop_front();
          ew = (e.code == 2'd3) ? e.addr : 64'd0;
          check(res_code == e.code, {e.tag, " code"}, 64'(res_code), 64'(e.code));
          check(res_addr == e.addr, {e.tag, " addr"}, res_addr, e.addr);
          check({res_evt_w7, res_evt_w6} == ew, {e.tag, " R8 event words"},
                {res_evt_w7, res_evt_w6}, ew);
          check((n_rd - rd_at_last) == e.reads, {e.tag, " read count"},
                64'(n_rd - rd_at_last), 64'(e.reads));
          rd_at_last = n_rd;
        end
      end
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_sid = 0; cfg_base = 0; cfg_two_level = 0;
    cfg_log2size = 0; cfg_split = 0; cfg_impl_sidw = 0;
    mem_desc = 0; mem_err = 0; gnt_dly = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(req_ready == 1 && res_valid == 0 && rd_req == 0, "R1 reset state",
          {61'd0, req_ready, res_valid, rd_req}, 64'h4);

    // R3 R4 flat layout
    send(20'd5, 64'h0000_ABCD_1234_5678, 0, 8, 0, 16, 0, 0, 0, 0, "R4 flat");
    send(20'd3, 64'hFFF0_0000_0010_00FF, 0, 2, 0, 16, 0, 0, 0, 0, "R3 high bits masked");
    // R2 bound
    send(20'd64, 64'h1000_0000, 0, 6, 0, 16, 0, 0, 0, 0, "R2 bound faults");
    send(20'd63, 64'h1000_0000, 0, 6, 0, 16, 0, 0, 0, 0, "R2 below bound ok");
    send(20'd16, 64'h1000_0000, 0, 12, 0, 4, 0, 0, 0, 0, "R2 impl width bound");
    send(20'd15, 64'h1000_0000, 0, 12, 0, 4, 0, 0, 0, 0, "R2 impl width ok");
    send(20'd1, 64'h1000_0000, 0, 0, 0, 16, 0, 0, 0, 0, "R2 size zero");
    send(20'd0, 64'h1000_0040, 0, 0, 0, 16, 0, 0, 0, 0, "R4 size zero ok");
    // R5 R6 two-level
    send(20'h123, 64'h0000_0012_3456_7FC0, 1, 10, 4, 16,
         64'h0000_0004_5678_9005, 0, 0, 0, "R6 two-level ok");
    send(20'h0AB, 64'h0000_0000_ABCD_FFC0, 1, 16, 2, 8,
         64'h0000_0000_2000_0003, 0, 2, 0, "R5 align ignores impl width");
    send(20'h07, 64'h0000_0000_0000_0FC0, 1, 4, 3, 16,
         64'h0000_0000_0001_0004, 0, 0, 0, "R5 minimum alignment");
    // R7
    send(20'h13, 64'h0000_0000_4000_0000, 1, 8, 4, 16,
         64'h0000_0000_0002_0000, 0, 0, 0, "R7 span zero");
    send(20'h19, 64'h0000_0000_4000_0000, 1, 8, 4, 16,
         64'h0000_0000_0002_0004, 0, 0, 0, "R7 index beyond span");
    send(20'h17, 64'h0000_0000_4000_0000, 1, 8, 4, 16,
         64'h0000_0000_0002_0004, 0, 0, 0, "R7 last index in span");
    // R8
    send(20'h2C, 64'h0001_2345_6780_0000, 1, 8, 2, 16,
         64'h0000_0000_0002_0005, 1, 1, 0, "R8 fetch fault");
    // R9 R10 back to back with scrambled config
    send(20'h31, 64'h0000_0777_0000_0000, 1, 9, 3, 16,
         64'h0000_0000_0300_0004, 0, 0, 1, "R10 two-level scrambled");
    send(20'h21, 64'h0000_0000_5555_0000, 0, 7, 0, 16, 0, 0, 0, 1, "R10 flat scrambled");
    send(20'h80, 64'h0000_0000_5555_0000, 0, 7, 0, 16, 0, 0, 0, 1, "R10 R2 scrambled");
    send(20'h40, 64'h0000_0000_6000_0000, 0, 7, 0, 16, 0, 0, 0, 0, "R9 back to back");

    repeat (20) @(negedge clk);
    check(q.size() == 0, "R9 all results delivered", 64'(q.size()), 0);
    done = 1;
    summary();
  end
endmodule